// File: doc/BRIEF.md
# Interval Timer with Trap-Number Mapping and Time-of-Day Counter

This block pairs a periodic interval timer with a free-running time-of-day counter. Software programs a control word and a reload period. The control word holds an enable flag, a 4-bit priority and an 8-bit trap number. While the timer is enabled it counts down and raises a one-cycle interrupt request. The request comes with a trap number and a priority for the interrupt controller nearby. A static mode input selects how the trap number is formed. In legacy mode the trap number and the priority pass through as separate fields. In compact mode the trap number is confined to the window 64..127 and the priority is folded into bits 5:2 of it.

The time-of-day counter keeps a 64-bit seconds count and a nanoseconds count below one billion. Each clock adds a fixed nanoseconds increment, set by a parameter. When the nanoseconds count passes one second it carries into the seconds count in the same cycle. Software reads the seconds count as two 32-bit halves. Reading the upper half also captures the lower half and the nanoseconds in a snapshot, so that a three-word read gives one consistent time. Software may load any of the time words directly.

Top module: `itmr_timebase`

## Requirements
- R1: Register 0 is the control word. Bit 26 is enable, bits 23:20 are the priority and bits 19:12 are the trap number. Every other bit is dropped on write and reads back as zero.
- R2: Register 1 holds the reload period and reads back as written. Any write to register 0 loads the countdown from the period. While enabled, the first request comes PERIOD+1 cycles after that write edge and further requests follow every PERIOD+1 cycles.
- R3: With a period of 0 and the timer enabled, a request is raised on every cycle.
- R4: While the enable bit is clear, no request is raised. A write to register 0 also cancels a request in that cycle.
- R5: When `compact_mode` is 0, `irq_trap` equals the programmed trap number and `irq_prio` equals the programmed priority.
- R6: When `compact_mode` is 1, `irq_trap` is {2'b01, num[5:0] | (prio << 2)}. Example: num 0xC5 with prio 0xA gives 0x6D. `irq_prio` still carries the priority.
- R7: When no time word is written, the nanoseconds count grows by NS_STEP (default 5) on every clock, as long as the sum stays below 1,000,000,000.
- R8: When the sum reaches or passes 1,000,000,000, the new nanoseconds count is the sum minus 1,000,000,000. The 64-bit seconds count grows by one on that same edge, carrying from the low word into the high word.
- R9: Register 2 returns the live upper seconds word. A read of register 2 captures the lower seconds word and the nanoseconds count at that edge. Registers 3 and 4 return these captured values until the next read of register 2.
- R10: A write to register 2 or 3 (seconds) or 4 (nanoseconds) takes effect at the next edge in place of that cycle's increment. A nanoseconds write also suppresses that cycle's carry.
- R11: After reset, every register reads zero and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compact_mode | input | 1 | 0: separate trap and priority, 1: compact trap window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; needed for the snapshot on register 2 |
| bus_addr | input | 3 | Register index 0..4 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_trap | output | 8 | Trap number to present with the request |
| irq_prio | output | 4 | Priority to present with the request |

## Verification
The hardest situation to reach from the ports is a nanoseconds carry that also ripples from the low seconds word into the high word. Natural counting would need billions of cycles to get there. The stimulus instead loads the low seconds word with all ones and the nanoseconds count with a value a few steps short of one second. A snapshot read is then timed to fall on the cycle right after the wrap. A second case loads the value exactly one step short, to hit the equality edge. Request timing is checked by a scoreboard that predicts the cycle, trap number and priority of each pulse for periods 7, 3 and 0, in both mapping modes.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

   localparam int DATA_W       = 32;
   localparam int CTL_EN_BIT   = 26;
   localparam int CTL_PRIO_LSB = 20;
   localparam int CTL_NUM_LSB  = 12;
   localparam int PRIO_W       = 4;
   localparam int TRAP_W       = 8;

   typedef enum logic [2:0] {
      RA_CTRL   = 3'd0,
      RA_PERIOD = 3'd1,
      RA_SEC_HI = 3'd2,
      RA_SEC_LO = 3'd3,
      RA_NSEC   = 3'd4
   } reg_addr_e;

   typedef struct packed {
      logic              en;
      logic [PRIO_W-1:0] prio;
      logic [TRAP_W-1:0] num;
   } ctrl_t;

   function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
      ctrl_t c;
      c.en   = w[CTL_EN_BIT];
      c.prio = w[CTL_PRIO_LSB +: PRIO_W];
      c.num  = w[CTL_NUM_LSB +: TRAP_W];
      return c;
   endfunction

   function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
      logic [DATA_W-1:0] w;
      w = '0;
      w[CTL_EN_BIT]                = c.en;
      w[CTL_PRIO_LSB +: PRIO_W]    = c.prio;
      w[CTL_NUM_LSB +: TRAP_W]     = c.num;
      return w;
   endfunction

endpackage

// File: rtl/itmr_countdown.sv
module itmr_countdown #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             en,
   input  logic [CNT_W-1:0] period,
   output logic             cnt_zero,
   output logic             irq
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_w
         $error("itmr_countdown: CNT_W out of range");
      end
   endgenerate

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq   <= 1'b0;
      end else if (load) begin
         cnt_q <= period;
         irq   <= 1'b0;
      end else if (en) begin
         if (cnt_zero) begin
            cnt_q <= period;
            irq   <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
            irq   <= 1'b0;
         end
      end else begin
         irq <= 1'b0;
      end
   end

endmodule

// File: rtl/itmr_trap_map.sv
module itmr_trap_map #(
   parameter int TRAP_W     = 8,
   parameter int PRIO_W     = 4,
   parameter int PRIO_SHIFT = 2
) (
   input  logic              compact,
   input  logic [TRAP_W-1:0] num,
   input  logic [PRIO_W-1:0] prio,
   output logic [TRAP_W-1:0] trap
);

   localparam int WIN_MSB = TRAP_W - 2;

   logic [TRAP_W-1:0] packed_trap;

   generate
      if (PRIO_SHIFT + PRIO_W > WIN_MSB) begin : g_bad_fold
         $error("itmr_trap_map: priority does not fit below the window bit");
      end
      for (genvar b = 0; b < TRAP_W; b++) begin : g_bit
         if (b >= PRIO_SHIFT && b < PRIO_SHIFT + PRIO_W) begin : g_fold
            assign packed_trap[b] = num[b] | prio[b - PRIO_SHIFT];
         end else if (b < WIN_MSB) begin : g_keep
            assign packed_trap[b] = num[b];
         end else if (b == WIN_MSB) begin : g_one
            assign packed_trap[b] = 1'b1;
         end else begin : g_zero
            assign packed_trap[b] = 1'b0;
         end
      end
   endgenerate

   assign trap = compact ? packed_trap : num;

endmodule

// File: rtl/itmr_clock.sv
module itmr_clock #(
   parameter int          DATA_W  = 32,
   parameter int unsigned NS_STEP = 5,
   parameter int unsigned NS_LIM  = 1_000_000_000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_hi,
   input  logic                wr_lo,
   input  logic                wr_ns,
   input  logic                rd_hi,
   input  logic [DATA_W-1:0]   wdata,
   output logic [2*DATA_W-1:0] sec_q,
   output logic [DATA_W-1:0]   ns_q,
   output logic [DATA_W-1:0]   snap_lo,
   output logic [DATA_W-1:0]   snap_ns
);

   localparam int SUM_W = DATA_W + 1;
   localparam logic [SUM_W-1:0] STEP_EXT = SUM_W'(NS_STEP);
   localparam logic [SUM_W-1:0] LIM_EXT  = SUM_W'(NS_LIM);

   generate
      if (NS_STEP == 0 || NS_STEP >= NS_LIM) begin : g_bad_step
         $error("itmr_clock: NS_STEP must be in 1..NS_LIM-1");
      end
   endgenerate

   logic [SUM_W-1:0] ns_sum;
   logic             wrap;
   logic [DATA_W-1:0] ns_next;

   assign ns_sum = {1'b0, ns_q} + STEP_EXT;
   assign wrap   = (ns_sum >= LIM_EXT);

   always_comb begin
      if (wr_ns)      ns_next = wdata;
      else if (wrap)  ns_next = DATA_W'(ns_sum - LIM_EXT);
      else            ns_next = ns_sum[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ns_q  <= '0;
         sec_q <= '0;
      end else begin
         ns_q <= ns_next;
         if (wr_hi)                sec_q <= {wdata, sec_q[DATA_W-1:0]};
         else if (wr_lo)           sec_q <= {sec_q[2*DATA_W-1:DATA_W], wdata};
         else if (wrap && !wr_ns)  sec_q <= sec_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_lo <= '0;
         snap_ns <= '0;
      end else if (rd_hi) begin
         snap_lo <= sec_q[DATA_W-1:0];
         snap_ns <= ns_q;
      end
   end

endmodule

// File: rtl/itmr_timebase.sv
module itmr_timebase
   import itmr_pkg::*;
#(
   parameter int          PERIOD_W = 32,
   parameter int unsigned NS_STEP  = 5,
   parameter int unsigned NS_LIM   = 1_000_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              compact_mode,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_req,
   output logic [TRAP_W-1:0] irq_trap,
   output logic [PRIO_W-1:0] irq_prio
);

   generate
      if (PERIOD_W < 1 || PERIOD_W > DATA_W) begin : g_bad_period
         $error("itmr_timebase: PERIOD_W must fit in a data word");
      end
   endgenerate

   ctrl_t                  ctrl_q;
   logic [PERIOD_W-1:0]    period_q;
   logic                   ctrl_wr;
   logic                   period_wr;
   logic                   sec_hi_wr;
   logic                   sec_lo_wr;
   logic                   nsec_wr;
   logic                   sec_hi_rd;
   logic                   tmr_en;
   logic                   cnt_zero;
   logic [2*DATA_W-1:0]    sec_q;
   logic [DATA_W-1:0]      ns_q;
   logic [DATA_W-1:0]      snap_lo;
   logic [DATA_W-1:0]      snap_ns;

   assign ctrl_wr   = bus_wr && (bus_addr == RA_CTRL);
   assign period_wr = bus_wr && (bus_addr == RA_PERIOD);
   assign sec_hi_wr = bus_wr && (bus_addr == RA_SEC_HI);
   assign sec_lo_wr = bus_wr && (bus_addr == RA_SEC_LO);
   assign nsec_wr   = bus_wr && (bus_addr == RA_NSEC);
   assign sec_hi_rd = bus_rd && (bus_addr == RA_SEC_HI);
   assign tmr_en    = ctrl_q.en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
      end else begin
         if (ctrl_wr)   ctrl_q   <= ctrl_unpack(bus_wdata);
         if (period_wr) period_q <= bus_wdata[PERIOD_W-1:0];
      end
   end

   itmr_countdown #(
      .CNT_W (PERIOD_W)
   ) u_countdown (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctrl_wr),
      .en       (tmr_en),
      .period   (period_q),
      .cnt_zero (cnt_zero),
      .irq      (irq_req)
   );

   itmr_trap_map #(
      .TRAP_W     (TRAP_W),
      .PRIO_W     (PRIO_W),
      .PRIO_SHIFT (2)
   ) u_trap_map (
      .compact (compact_mode),
      .num     (ctrl_q.num),
      .prio    (ctrl_q.prio),
      .trap    (irq_trap)
   );

   assign irq_prio = ctrl_q.prio;

   itmr_clock #(
      .DATA_W  (DATA_W),
      .NS_STEP (NS_STEP),
      .NS_LIM  (NS_LIM)
   ) u_clock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (sec_hi_wr),
      .wr_lo   (sec_lo_wr),
      .wr_ns   (nsec_wr),
      .rd_hi   (sec_hi_rd),
      .wdata   (bus_wdata),
      .sec_q   (sec_q),
      .ns_q    (ns_q),
      .snap_lo (snap_lo),
      .snap_ns (snap_ns)
   );

   always_comb begin
      unique case (bus_addr)
         RA_CTRL:   bus_rdata = ctrl_pack(ctrl_q);
         RA_PERIOD: bus_rdata = DATA_W'(period_q);
         RA_SEC_HI: bus_rdata = sec_q[2*DATA_W-1:DATA_W];
         RA_SEC_LO: bus_rdata = snap_lo;
         RA_NSEC:   bus_rdata = snap_ns;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
   parameter int unsigned NS_STEP = 5,
   parameter int unsigned NS_LIM  = 1_000_000_000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        compact_mode,
   input logic        irq_req,
   input logic [7:0]  irq_trap,
   input logic [7:0]  prog_num,
   input logic        tmr_en,
   input logic        cnt_zero,
   input logic        ctrl_wr,
   input logic        nsec_wr,
   input logic        sec_wr,
   input logic        sec_hi_rd,
   input logic [31:0] wdata,
   input logic [63:0] sec_q,
   input logic [31:0] ns_q,
   input logic [31:0] snap_lo,
   input logic [31:0] snap_ns
);

   localparam logic [32:0] STEP33 = 33'(NS_STEP);
   localparam logic [32:0] LIM33  = 33'(NS_LIM);

   logic [32:0] ns_sum;
   assign ns_sum = {1'b0, ns_q} + STEP33;

   // R2: an expired countdown while enabled yields a request on the next edge
   a_r2_expiry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && cnt_zero && !ctrl_wr) |=> irq_req);

   // R4: disabled timer never raises a request
   a_r4_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en) |=> !irq_req);

   // R5: legacy mode passes the programmed number through
   a_r5_legacy_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (!compact_mode) |-> (irq_trap == prog_num));

   // R6: compact mode stays inside the 64..127 window
   a_r6_compact_window: assert property (@(posedge clk) disable iff (!rst_n)
      compact_mode |-> (irq_trap[7:6] == 2'b01));

   // R7: plain step without wrap
   a_r7_ns_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!nsec_wr && (ns_sum < LIM33)) |=> (ns_q == $past(ns_q) + NS_STEP));

   // R8: wrap carries into seconds on the same edge
   a_r8_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (!nsec_wr && !sec_wr && (ns_sum >= LIM33)) |=> (sec_q == $past(sec_q) + 64'd1));

   // R9: high-word read captures low word and nanoseconds
   a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      sec_hi_rd |=> ((snap_ns == $past(ns_q)) && (snap_lo == $past(sec_q[31:0]))));

   // R10: nanoseconds write overrides the increment
   a_r10_ns_override: assert property (@(posedge clk) disable iff (!rst_n)
      nsec_wr |=> (ns_q == $past(wdata)));

endmodule

bind itmr_timebase itmr_checker #(
   .NS_STEP (NS_STEP),
   .NS_LIM  (NS_LIM)
) u_itmr_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .compact_mode (compact_mode),
   .irq_req      (irq_req),
   .irq_trap     (irq_trap),
   .prog_num     (ctrl_q.num),
   .tmr_en       (tmr_en),
   .cnt_zero     (cnt_zero),
   .ctrl_wr      (ctrl_wr),
   .nsec_wr      (nsec_wr),
   .sec_wr       (sec_hi_wr || sec_lo_wr),
   .sec_hi_rd    (sec_hi_rd),
   .wdata        (bus_wdata),
   .sec_q        (sec_q),
   .ns_q         (ns_q),
   .snap_lo      (snap_lo),
   .snap_ns      (snap_ns)
);

// File: tb/itmr_timebase_bench.sv
`timescale 1ns/1ps
module itmr_timebase_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        compact_mode = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        irq_req;
   logic [7:0]  irq_trap;
   logic [3:0]  irq_prio;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int unexpected = 0;
   int pulses_seen = 0;
   bit done = 1'b0;
   logic [43:0] exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   itmr_timebase u_itmr_timebase (
      .clk          (clk),
      .rst_n        (rst_n),
      .compact_mode (compact_mode),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .irq_req      (irq_req),
      .irq_trap     (irq_trap),
      .irq_prio     (irq_prio)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ctl(input bit en, input logic [3:0] prio, input logic [7:0] num);
      return (32'(en) << 26) | (32'(prio) << 20) | (32'(num) << 12);
   endfunction

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && irq_req) begin
         pulses_seen++;
         if (exp_q.size() == 0) begin
            unexpected++;
         end else begin
            logic [43:0] it;
            it = exp_q.pop_front();
            chk(it[43:12] == 32'(cyc), "R2 request cycle", 64'(cyc), 64'(it[43:12]));
            chk(it[11:4] == irq_trap, compact_mode ? "R6 trap" : "R5 trap", 64'(irq_trap), 64'(it[11:4]));
            chk(it[3:0] == irq_prio, compact_mode ? "R6 prio" : "R5 prio", 64'(irq_prio), 64'(it[3:0]));
         end
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver side: predict a run of pulses
   task automatic push_pulses(input int start, input int gap, input int n, input logic [7:0] trap, input logic [3:0] prio);
      for (int i = 1; i <= n; i++) exp_q.push_back({32'(start + gap * i), trap, prio});
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
      chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int c0;
      int tw;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R11: reset state
      chk(irq_req == 1'b0, "R11 irq low", 64'(irq_req), 64'd0);
      bus_read(3'd0, d); chk(d == 32'd0, "R11 control", 64'(d), 64'd0);
      bus_read(3'd1, d); chk(d == 32'd0, "R11 period", 64'(d), 64'd0);
      bus_read(3'd2, d); chk(d == 32'd0, "R11 seconds high", 64'(d), 64'd0);

      // R1: masked control fields, enable off
      bus_write(3'd0, 32'hA1A5_A5A5);
      bus_read(3'd0, d); chk(d == 32'h00A5_A000, "R1 control mask", 64'(d), 64'h00A5A000);
      idle(20);
      chk(pulses_seen == 0, "R4 no request while disabled", 64'(pulses_seen), 64'd0);

      // R2: period readback and legacy periodic requests
      bus_write(3'd1, 32'd7);
      bus_read(3'd1, d); chk(d == 32'd7, "R2 period readback", 64'(d), 64'd7);
      bus_write(3'd0, ctl(1'b1, 4'hA, 8'hC5));
      c0 = cyc;
      push_pulses(c0, 8, 3, 8'hC5, 4'hA);
      drain("R2 legacy pulses delivered");

      // R4: disable stops requests
      bus_write(3'd0, ctl(1'b0, 4'hA, 8'hC5));
      idle(40);
      chk(unexpected == 0, "R4 nothing after disable", 64'(unexpected), 64'd0);

      // R6: compact mapping, period 3
      compact_mode = 1'b1;
      bus_write(3'd1, 32'd3);
      bus_write(3'd0, ctl(1'b1, 4'hA, 8'hC5));
      c0 = cyc;
      push_pulses(c0, 4, 3, 8'h6D, 4'hA);
      drain("R6 compact pulses delivered");
      bus_write(3'd0, ctl(1'b0, 4'hF, 8'h3F));
      chk(irq_trap == 8'h7F, "R6 full fold", 64'(irq_trap), 64'h7F);
      idle(10);

      // R3: period 0 gives a request every cycle
      compact_mode = 1'b0;
      bus_write(3'd1, 32'd0);
      pulses_seen = 0;
      bus_write(3'd0, ctl(1'b1, 4'h3, 8'h12));
      c0 = cyc;
      push_pulses(c0, 1, 3, 8'h12, 4'h3);
      idle(3);
      bus_write(3'd0, ctl(1'b0, 4'h3, 8'h12));
      idle(10);
      chk(exp_q.size() == 0, "R3 back-to-back requests", 64'(exp_q.size()), 64'd0);
      chk(pulses_seen == 3, "R3 pulse count", 64'(pulses_seen), 64'd3);
      chk(unexpected == 0, "R4 write cancels request", 64'(unexpected), 64'd0);

      // R10 / R9: direct writes and a snapshot read
      bus_write(3'd2, 32'h0000_1234);
      bus_write(3'd3, 32'h5678_9ABC);
      bus_write(3'd4, 32'd100);
      tw = cyc;
      bus_read(3'd2, d); chk(d == 32'h1234, "R10 seconds high write", 64'(d), 64'h1234);
      bus_read(3'd3, d); chk(d == 32'h5678_9ABC, "R9 snapshot low", 64'(d), 64'h56789ABC);
      bus_read(3'd4, d); chk(d == 32'd100, "R10 ns write overrides step", 64'(d), 64'd100);
      idle(10);
      bus_read(3'd4, d); chk(d == 32'd100, "R9 snapshot held", 64'(d), 64'd100);

      // R7: step per cycle, measured by a second snapshot
      c0 = cyc;
      bus_read(3'd2, d);
      bus_read(3'd4, d);
      chk(d == 32'(100 + 5 * (c0 - tw)), "R7 ns step", 64'(d), 64'(100 + 5 * (c0 - tw)));

      // R8: wrap past the limit with carry into the high word
      bus_write(3'd2, 32'd0);
      bus_write(3'd3, 32'hFFFF_FFFF);
      bus_write(3'd4, 32'd999_999_997);
      idle(1);
      bus_read(3'd2, d); chk(d == 32'd1, "R8 carry into high word", 64'(d), 64'd1);
      bus_read(3'd3, d); chk(d == 32'd0, "R8 low word wrapped", 64'(d), 64'd0);
      bus_read(3'd4, d); chk(d == 32'd2, "R8 ns remainder", 64'(d), 64'd2);

      // R8: exact landing on the limit
      bus_write(3'd3, 32'd7);
      bus_write(3'd4, 32'd999_999_995);
      idle(1);
      bus_read(3'd2, d);
      bus_read(3'd3, d); chk(d == 32'd8, "R8 exact limit carry", 64'(d), 64'd8);
      bus_read(3'd4, d); chk(d == 32'd0, "R8 exact limit ns", 64'(d), 64'd0);

      chk(unexpected == 0, "R4 no stray requests", 64'(unexpected), 64'd0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule